// File: doc/BRIEF.md
# Indexed Block-Transfer Serial Bus Target

This block is a two-wire serial bus target (SMBus/I2C style) that serves only indexed block transfers against a small internal byte-wide register array. It oversamples the clock and data lines with the system clock, finds START, repeated START and STOP conditions, and pulls the data line low through an output-enable signal. The data output itself is always low.

A write carries, in order: the target address with the write bit, a starting index, a byte count and then that many data bytes. The data bytes are stored at consecutive indices. A read first sets the starting index with a short write. It then issues a repeated START and the address with the read bit. The target answers with a count byte, followed by data bytes taken from consecutive indices. The count the target sends comes from a programmable count register at index 7, not from the host. The 7-bit target address is taken from a strap input once, during reset.

The index width, the synchronizer depth, the slot of the count register and its reset value are parameters.

Top module: `smb_block_target`

## Requirements
- R1: For a write to the own address with the write bit, the target acknowledges the address byte, the index byte N, the count byte X and each of the X data bytes, and stores the data bytes at indices N, N+1, ... N+X-1.
- R2: In a write, every data byte after the first X is not acknowledged and is not stored, and the target stays silent until the next START or STOP.
- R3: After index N has been set and a repeated START with the own address and read bit (address byte LSB = 1) has been acknowledged, the target sends the count byte first and then the data bytes from index N upward, MSB first.
- R4: The number of data bytes sent on a read equals the count register, held at index 7 and written like any other index. Reading index 7 returns the count register. After that many data bytes the target releases SDA, so further bytes read as 0xFF.
- R5: A NACK from the host after any byte the target sent makes the target release SDA until the next START or STOP.
- R6: An address byte whose upper 7 bits differ from the own address gets no acknowledge. Until the next START, no byte is acknowledged and nothing is stored.
- R7: The own address is captured from the strap input while rst is high. Later changes of the strap have no effect.
- R8: Only the low 4 bits of the index byte are used (16 entries). The index advances by one after each stored or sent data byte and wraps from 15 to 0.
- R9: A STOP or START that arrives before a byte is complete discards the partial byte, and nothing is stored.
- R10: A STOP resets the index to 0, so a read that starts directly with the read address returns data from index 0. A repeated START keeps the index.
- R11: The target changes its SDA drive only while SCL is low.
- R12: After reset SDA is released, and the count register holds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset, also captures the strap |
| strap_addr | input | 7 | Target address strap, captured during reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_o | output | 1 | Data value driven when enabled, constant 0 |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The bench targets the count boundary: bytes past X, sent by the host in a write or clocked by the host in a read. A design with an off-by-one count would store one byte too many or send stale array data where 0xFF is expected. Index wrap is exercised across 15 to 0 and with an index byte whose high bits are set. A design that failed to wrap would write outside the array, and one that failed to mask would read the wrong entries. Aborts by STOP and by START partway through a byte are checked. A design that committed the partial shift register would corrupt the addressed entry. The tests also cover a mismatching address, a strap that changes after reset, and a read without an index phase after STOP. In those cases a faulty design would acknowledge a foreign address, follow the live strap, or start at a stale index.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACKO,
    PH_TX,
    PH_ACKI,
    PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_IDX,
    K_CNT,
    K_DATA
  } kind_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl   = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_p;
  assign scl_fall  = ~scl_lvl & scl_p;
  assign start_det = scl_lvl & scl_p & sda_p & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_p & ~sda_p & sda_lvl;

endmodule

// File: rtl/smb_reg_array.sv
module smb_reg_array #(
  parameter int IDX_W   = 4,
  parameter int CNT_IDX = 7,
  parameter int CNT_RST = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata,
  output logic [7:0]       cnt_q
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] CNT_SLOT = CNT_IDX[IDX_W-1:0];

  logic [7:0] mem [DEPTH];
  logic [7:0] mem_q;
  logic       sel_cnt_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= 8'(CNT_RST);
      sel_cnt_q <= 1'b0;
    end else begin
      if (we && waddr == CNT_SLOT) cnt_q <= wdata;
      sel_cnt_q <= (raddr == CNT_SLOT);
    end
  end

  assign rdata = sel_cnt_q ? cnt_q : mem_q;

  AST_CNT_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != $past(cnt_q)) |-> $past(we && waddr == CNT_SLOT)); // R4

endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
  import smb_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_lvl,
  input  logic [6:0]       own_addr,
  input  logic [7:0]       rd_byte,
  input  logic [7:0]       cnt_val,
  output logic             sda_oe,
  output logic             we_q,
  output logic [IDX_W-1:0] widx_q,
  output logic [7:0]       wdata_q,
  output logic [IDX_W-1:0] ridx
);

  localparam logic [IDX_W-1:0] IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};

  phase_t           phase_q;
  kind_t            kind_q;
  logic [3:0]       bitcnt_q;
  logic [7:0]       rx_sh_q;
  logic [7:0]       tx_sh_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       rem_q;
  logic             tx_next_q;
  logic             first_q;
  logic             host_ack_q;
  logic             do_load;
  logic [7:0]       ld_val;

  assign ridx = idx_q;

  always_comb begin
    if (first_q)           ld_val = cnt_val;
    else if (rem_q != 8'd0) ld_val = rd_byte;
    else                   ld_val = 8'hFF;
  end

  assign do_load = scl_fall &&
                   ((phase_q == PH_ACKO && tx_next_q) ||
                    (phase_q == PH_ACKI && host_ack_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      kind_q     <= K_ADDR;
      bitcnt_q   <= 4'd0;
      rx_sh_q    <= 8'd0;
      tx_sh_q    <= 8'd0;
      idx_q      <= '0;
      rem_q      <= 8'd0;
      tx_next_q  <= 1'b0;
      first_q    <= 1'b0;
      host_ack_q <= 1'b0;
      sda_oe     <= 1'b0;
      we_q       <= 1'b0;
      widx_q     <= '0;
      wdata_q    <= 8'd0;
    end else begin
      we_q <= 1'b0;
      if (stop_det) begin
        phase_q  <= PH_IDLE;
        sda_oe   <= 1'b0;
        idx_q    <= '0;
        bitcnt_q <= 4'd0;
      end else if (start_det) begin
        phase_q  <= PH_RX;
        kind_q   <= K_ADDR;
        bitcnt_q <= 4'd0;
        sda_oe   <= 1'b0;
      end else begin
        case (phase_q)
          PH_RX: begin
            if (scl_rise) begin
              rx_sh_q  <= {rx_sh_q[6:0], sda_lvl};
              bitcnt_q <= bitcnt_q + 4'd1;
            end else if (scl_fall && bitcnt_q == 4'd8) begin
              bitcnt_q <= 4'd0;
              case (kind_q)
                K_ADDR: begin
                  if (rx_sh_q[7:1] == own_addr) begin
                    sda_oe  <= 1'b1;
                    phase_q <= PH_ACKO;
                    if (rx_sh_q[0]) begin
                      tx_next_q <= 1'b1;
                      first_q   <= 1'b1;
                    end else begin
                      tx_next_q <= 1'b0;
                      kind_q    <= K_IDX;
                    end
                  end else begin
                    phase_q <= PH_SKIP;
                  end
                end
                K_IDX: begin
                  idx_q   <= rx_sh_q[IDX_W-1:0];
                  sda_oe  <= 1'b1;
                  phase_q <= PH_ACKO;
                  kind_q  <= K_CNT;
                end
                K_CNT: begin
                  rem_q   <= rx_sh_q;
                  sda_oe  <= 1'b1;
                  phase_q <= PH_ACKO;
                  kind_q  <= K_DATA;
                end
                default: begin
                  if (rem_q != 8'd0) begin
                    we_q    <= 1'b1;
                    widx_q  <= idx_q;
                    wdata_q <= rx_sh_q;
                    idx_q   <= idx_q + IDX_ONE;
                    rem_q   <= rem_q - 8'd1;
                    sda_oe  <= 1'b1;
                    phase_q <= PH_ACKO;
                  end else begin
                    phase_q <= PH_SKIP;
                  end
                end
              endcase
            end
          end
          PH_ACKO: begin
            if (scl_fall) begin
              sda_oe   <= 1'b0;
              phase_q  <= PH_RX;
              bitcnt_q <= 4'd0;
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (bitcnt_q == 4'd8) begin
                sda_oe  <= 1'b0;
                phase_q <= PH_ACKI;
              end else begin
                sda_oe   <= ~tx_sh_q[7];
                tx_sh_q  <= {tx_sh_q[6:0], 1'b0};
                bitcnt_q <= bitcnt_q + 4'd1;
              end
            end
          end
          PH_ACKI: begin
            if (scl_rise) begin
              host_ack_q <= ~sda_lvl;
            end else if (scl_fall && !host_ack_q) begin
              sda_oe  <= 1'b0;
              phase_q <= PH_SKIP;
            end
          end
          default: ;
        endcase
        if (do_load) begin
          tx_sh_q  <= {ld_val[6:0], 1'b0};
          sda_oe   <= ~ld_val[7];
          bitcnt_q <= 4'd1;
          phase_q  <= PH_TX;
          if (first_q) begin
            first_q <= 1'b0;
            rem_q   <= cnt_val;
          end else if (rem_q != 8'd0) begin
            idx_q <= idx_q + IDX_ONE;
            rem_q <= rem_q - 8'd1;
          end
        end
      end
    end
  end

  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SKIP) |-> !sda_oe); // R6

  AST_WRITE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    we_q |-> ($past(rem_q) != 8'd0)); // R2

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (idx_q == '0 && !sda_oe)); // R10

endmodule

// File: rtl/smb_block_target.sv
module smb_block_target #(
  parameter int IDX_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_IDX     = 7,
  parameter int CNT_RST     = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [6:0] strap_addr,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_o,
  output logic       sda_oe
);

  logic [6:0]       own_q;
  logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic             we;
  logic [IDX_W-1:0] widx, ridx;
  logic [7:0]       wdata, rdata, cnt_val;

  always_ff @(posedge clk) begin
    if (rst) own_q <= strap_addr;
  end

  assign sda_o = 1'b0;

  smb_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_xfer_fsm #(.IDX_W(IDX_W)) i_fsm (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_lvl   (sda_lvl),
    .own_addr  (own_q),
    .rd_byte   (rdata),
    .cnt_val   (cnt_val),
    .sda_oe    (sda_oe),
    .we_q      (we),
    .widx_q    (widx),
    .wdata_q   (wdata),
    .ridx      (ridx)
  );

  smb_reg_array #(
    .IDX_W   (IDX_W),
    .CNT_IDX (CNT_IDX),
    .CNT_RST (CNT_RST)
  ) i_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .waddr (widx),
    .wdata (wdata),
    .raddr (ridx),
    .rdata (rdata),
    .cnt_q (cnt_val)
  );

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> (!scl_lvl || $past(stop_det) || $past(start_det))); // R11

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(own_q)); // R7

endmodule

// File: tb/test_smb_block_target.sv
`timescale 1ns/1ps
module test_smb_block_target;

  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h5A;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] strap = OWN;
  logic       scl_drv = 1'b1;
  logic       sda_drv = 1'b1;
  logic       sda_o, sda_oe;
  wire        sda_bus = sda_drv & ~sda_oe;

  int checks = 0;
  int failures = 0;
  int viol = 0;
  logic oe_prev = 1'b0;
  logic [7:0] sb [16];
  logic [7:0] cnt_sb = 8'd8;
  logic [7:0] wbuf [32];
  logic [6:0] host_addr = OWN;

  always #10 clk = ~clk;

  smb_block_target i_smb_block_target (
    .clk        (clk),
    .rst        (rst),
    .strap_addr (strap),
    .scl_i      (scl_drv),
    .sda_i      (sda_bus),
    .sda_o      (sda_o),
    .sda_oe     (sda_oe)
  );

  // R11 monitor: drive must not change while SCL is high
  always @(negedge clk) begin
    if (!rst && scl_drv && sda_oe !== oe_prev) viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q_wait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic h_start();
    sda_drv = 1'b1; scl_drv = 1'b1; q_wait();
    sda_drv = 1'b0; q_wait();
    scl_drv = 1'b0; q_wait();
  endtask

  task automatic h_stop();
    sda_drv = 1'b0; q_wait();
    scl_drv = 1'b1; q_wait();
    sda_drv = 1'b1; q_wait();
  endtask

  task automatic h_wbit(input logic b);
    sda_drv = b; q_wait();
    scl_drv = 1'b1; q_wait(); q_wait();
    scl_drv = 1'b0; q_wait();
  endtask

  task automatic h_rbit(output logic b);
    sda_drv = 1'b1; q_wait();
    scl_drv = 1'b1; q_wait();
    b = sda_bus; q_wait();
    scl_drv = 1'b0; q_wait();
  endtask

  task automatic h_wbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) h_wbit(v[i]);
    h_rbit(b);
    ack = ~b;
  endtask

  task automatic h_rbyte(output logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) h_rbit(v[i]);
    h_wbit(~ack);
  endtask

  function automatic logic [7:0] sbval(input int k);
    return (k == 7) ? cnt_sb : sb[k];
  endfunction

  // write: wbuf[0..nsend-1] sent, first x expected stored
  task automatic t_write(input logic [7:0] n, input logic [7:0] x, input int nsend,
                         input bit match, input string req);
    logic ack;
    h_start();
    h_wbyte({host_addr, 1'b0}, ack);
    chk(ack == match, {req, " addr ack"}, ack, match);
    h_wbyte(n, ack);
    chk(ack == match, {req, " index ack"}, ack, match);
    h_wbyte(x, ack);
    chk(ack == match, {req, " count ack"}, ack, match);
    for (int i = 0; i < nsend; i++) begin
      h_wbyte(wbuf[i], ack);
      chk(ack == (match && i < int'(x)), {req, " data ack"}, ack, (match && i < int'(x)));
      if (match && i < int'(x)) begin
        sb[(int'(n) + i) % 16] = wbuf[i];
        if ((int'(n) + i) % 16 == 7) cnt_sb = wbuf[i];
      end
    end
    h_stop();
  endtask

  // read: nclk data bytes clocked, last one NACKed
  task automatic t_read(input logic [7:0] n, input int nclk, input bit use_idx, input string req);
    logic ack;
    logic [7:0] v, exp;
    int base;
    h_start();
    if (use_idx) begin
      h_wbyte({host_addr, 1'b0}, ack);
      chk(ack, {req, " addr-w ack"}, ack, 1);
      h_wbyte(n, ack);
      chk(ack, {req, " index ack"}, ack, 1);
      sda_drv = 1'b1; q_wait();
      h_start();
      base = int'(n[3:0]);
    end else begin
      base = 0;
    end
    h_wbyte({host_addr, 1'b1}, ack);
    chk(ack, {req, " addr-r ack"}, ack, 1);
    h_rbyte(v, nclk != 0);
    chk(v == cnt_sb, {req, " count byte"}, v, cnt_sb);
    for (int i = 0; i < nclk; i++) begin
      h_rbyte(v, i != nclk - 1);
      exp = (i < int'(cnt_sb)) ? sbval((base + i) % 16) : 8'hFF;
      chk(v == exp, {req, " data byte"}, v, exp);
    end
    h_stop();
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R12 released after reset", sda_oe, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 7; i++) wbuf[i] = 8'hA0 + 8'(i);
    t_write(8'd0, 8'd7, 7, 1'b1, "R1 fill low");
    for (int i = 0; i < 8; i++) wbuf[i] = 8'h58 + 8'(i * 3);
    t_write(8'd8, 8'd8, 8, 1'b1, "R1 fill high");
  endtask

  task automatic t_read_default();
    t_read(8'd0, 9, 1'b1, "R3 R4 R12 default count");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hE0 + 8'(i);
    t_write(8'h1E, 8'd4, 4, 1'b1, "R8 wrap write");
    wbuf[0] = 8'd3;
    t_write(8'd7, 8'd1, 1, 1'b1, "R4 program count");
    t_read(8'd14, 4, 1'b1, "R4 R8 wrap read");
  endtask

  task automatic t_over();
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3; wbuf[3] = 8'hC4;
    t_write(8'd2, 8'd2, 4, 1'b1, "R2 excess bytes");
    t_read(8'd2, 3, 1'b1, "R2 readback");
  endtask

  task automatic t_nack();
    logic ack;
    logic [7:0] v;
    h_start();
    h_wbyte({host_addr, 1'b0}, ack);
    h_wbyte(8'd9, ack);
    sda_drv = 1'b1; q_wait();
    h_start();
    h_wbyte({host_addr, 1'b1}, ack);
    h_rbyte(v, 1'b1);
    h_rbyte(v, 1'b0);
    chk(v == sb[9], "R5 byte before nack", v, sb[9]);
    h_rbyte(v, 1'b0);
    chk(v == 8'hFF, "R5 released after nack", v, 8'hFF);
    h_stop();
  endtask

  task automatic t_mismatch();
    host_addr = OWN ^ 7'h01;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    t_write(8'd0, 8'd2, 2, 1'b0, "R6 foreign address");
    host_addr = OWN;
    t_read(8'd0, 2, 1'b1, "R6 array untouched");
  endtask

  task automatic t_strap();
    strap = 7'h13;
    host_addr = 7'h13;
    wbuf[0] = 8'h77;
    t_write(8'd1, 8'd1, 1, 1'b0, "R7 new strap ignored");
    host_addr = OWN;
    wbuf[0] = 8'h66;
    t_write(8'd1, 8'd1, 1, 1'b1, "R7 latched address");
    t_read(8'd1, 1, 1'b1, "R7 readback");
  endtask

  task automatic t_abort();
    logic ack;
    h_start();
    h_wbyte({host_addr, 1'b0}, ack);
    h_wbyte(8'd5, ack);
    h_wbyte(8'd1, ack);
    for (int i = 0; i < 4; i++) h_wbit(1'b0);
    h_stop();
    t_read(8'd5, 1, 1'b1, "R9 stop mid-byte");
    h_start();
    h_wbyte({host_addr, 1'b0}, ack);
    h_wbyte(8'd5, ack);
    h_wbyte(8'd1, ack);
    for (int i = 0; i < 3; i++) h_wbit(1'b0);
    sda_drv = 1'b1; q_wait();
    h_start();
    h_wbyte({host_addr, 1'b0}, ack);
    chk(ack, "R9 restart addr ack", ack, 1);
    h_wbyte(8'd6, ack);
    h_wbyte(8'd1, ack);
    h_wbyte(8'h3C, ack);
    chk(ack, "R9 restart data ack", ack, 1);
    sb[6] = 8'h3C;
    h_stop();
    t_read(8'd5, 2, 1'b1, "R9 start mid-byte");
  endtask

  task automatic t_stopidx();
    t_read(8'd0, 3, 1'b0, "R10 index cleared by stop");
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_fill();
    t_read_default();
    t_wrap();
    t_over();
    t_nack();
    t_mismatch();
    t_strap();
    t_abort();
    t_stopidx();
    chk(viol == 0, "R11 drive change with SCL high", viol, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule